// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block converts serial scans into accesses on a small parallel register bus. A test controller drives capture, shift and update strobes, together with a serial input bit. The block returns a serial output bit. Each scan word is 40 bits long. After the update strobe, the word is decoded into a 32-bit data field, a 7-bit register address and a direction bit. The block then issues either a write strobe or a read strobe on the register bus. Each strobe lasts one clock cycle.

Reads take two scans. The first scan names the register, and the bus read happens right after that scan's update. The capture phase of the following scan loads the returned value into the data field, where it is shifted out. Each read can change state in the addressed register. For this reason, each read update produces exactly one bus read, and a trailing scan can point at a harmless register to collect the last value.

The block responds only while a 5-bit chain number of zero is held. That number is loaded through a separate strobe. With any other chain number, all scan activity is ignored.

Top module: `scan_reg_port`

## Requirements
- R1: While reset is low and just after it, `busWrite`, `busRead` and `tdo` are 0. The chain number resets to all ones, which means the port is deselected.
- R2: Shifting is LSB first. Each shift moves `tdi` into scan bit 39 and drives scan bit 0 on `tdo`. Scan bits 0 to 31 hold data, bits 32 to 38 hold the address, and bit 39 is the direction bit (1 = write, 0 = read).
- R3: An update with direction 1 and an in-range address raises `busWrite` for exactly the one cycle after the update. During that cycle, `busAddr` and `busWdata` carry the scanned address and data.
- R4: An update with direction 0 and an in-range address raises `busRead` for exactly the one cycle after the update, with `busAddr` set to that address. Each such update produces exactly one bus read, and `busWrite` and `busRead` are never high together.
- R5: The capture of the next scan loads the value read into scan bits 0 to 31 and loads zeros into bits 32 to 39.
- R6: A capture in the same cycle as the read strobe loads the `busRdata` of that cycle.
- R7: An address equal to or above `NUM_REGS` (default 9) produces no strobe on update. A read of such an address makes the next capture return 0.
- R8: A capture that follows a write scan returns 0 in all 40 bits.
- R9: A chain number is stored when `chainLoad` is high. Only chain 0 is active. While another chain is selected, capture, shift and update have no effect, `tdo` stays 0, and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chainLoad | input | 1 | Store `chainIn` as the selected chain |
| chainIn | input | 5 | Chain number to select |
| captureEn | input | 1 | Capture strobe: load the scan register |
| shiftEn | input | 1 | Shift strobe: move the scan register one bit |
| updateEn | input | 1 | Update strobe: decode the scan word and start a bus access |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| busAddr | output | 7 | Register address for the bus access |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid for `busAddr` |
| busWrite | output | 1 | One-cycle write strobe |
| busRead | output | 1 | One-cycle read strobe |

## Verification
The capture of a scan and the bus read requested by the previous scan can fall in the same cycle. This happens when a new scan starts immediately after an update, with no idle cycle. The bench provokes this with back-to-back scans. It expects the forwarded `busRdata` in the captured word, and it also expects the single read strobe to still appear once. A scoreboard queues every expected bus strobe before the update. A monitor matches each strobe as it appears, so a repeated or missing strobe is reported alongside the captured words.

// File: rtl/scan_reg_port_pkg.sv
package scan_reg_port_pkg;

  // Strobes handed from control to datapath, all valid in the same cycle
  typedef struct packed {
    logic active;   // selected chain is the one this port answers on
    logic capture;  // load scan register this cycle
    logic shift;    // shift scan register this cycle
    logic update;   // latch address/data this cycle
    logic wrStb;    // bus write strobe (cycle after update)
    logic rdStb;    // bus read strobe (cycle after update)
  } scanCtlT;

endpackage

// File: rtl/scan_reg_port_ctl.sv
module scan_reg_port_ctl
  import scan_reg_port_pkg::*;
#(
  parameter int CHAIN_W      = 5,
  parameter int ACTIVE_CHAIN = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chainLoad,
  input  logic [CHAIN_W-1:0] chainIn,
  input  logic               captureEn,
  input  logic               shiftEn,
  input  logic               updateEn,
  input  logic               fieldWrite,
  input  logic               fieldAddrOk,
  output scanCtlT            ctlBus
);

  localparam logic [CHAIN_W-1:0] SEL_CHAIN = CHAIN_W'(ACTIVE_CHAIN);

  logic [CHAIN_W-1:0] chainReg;
  logic               active;
  logic               wrStbQ;
  logic               rdStbQ;
  logic               doUpdate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainReg <= '1;
    end else if (chainLoad) begin
      chainReg <= chainIn;
    end
  end

  assign active   = (chainReg == SEL_CHAIN);
  assign doUpdate = active & updateEn;

  // Bus strobes: registered, so they sit exactly one cycle after update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrStbQ <= 1'b0;
      rdStbQ <= 1'b0;
    end else begin
      wrStbQ <= doUpdate &  fieldWrite & fieldAddrOk;
      rdStbQ <= doUpdate & ~fieldWrite & fieldAddrOk;
    end
  end

  always_comb begin
    ctlBus.active  = active;
    ctlBus.capture = active & captureEn;
    ctlBus.shift   = active & shiftEn & ~captureEn;
    ctlBus.update  = doUpdate;
    ctlBus.wrStb   = wrStbQ;
    ctlBus.rdStb   = rdStbQ;
  end

  // R3: write strobe never lasts beyond one cycle
  a_r3_wr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrStbQ |=> !wrStbQ);

  // R4: read and write strobes are exclusive
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrStbQ, rdStbQ}));

  // R9: no bus strobe follows a cycle in which the port was deselected
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !$past(active) |-> !(wrStbQ || rdStbQ));

endmodule

// File: rtl/scan_reg_port_dp.sv
module scan_reg_port_dp
  import scan_reg_port_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtlT           ctlBus,
  input  logic              tdi,
  output logic              tdo,
  output logic              fieldWrite,
  output logic              fieldAddrOk,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata
);

  localparam int SCAN_W   = DATA_W + ADDR_W + 1;
  localparam int ADDR_LSB = DATA_W;
  localparam int RW_BIT   = SCAN_W - 1;
  localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [SCAN_W-1:0] shiftReg;
  logic [DATA_W-1:0] holdReg;
  logic [SCAN_W-1:0] captureWord;
  logic [DATA_W-1:0] readValue;
  logic [ADDR_W-1:0] fieldAddr;
  logic [DATA_W-1:0] fieldData;

  // Field decode
  assign fieldData   = shiftReg[DATA_W-1:0];
  assign fieldAddr   = shiftReg[RW_BIT-1:ADDR_LSB];
  assign fieldWrite  = shiftReg[RW_BIT];
  assign fieldAddrOk = ({1'b0, fieldAddr} < ADDR_LIMIT);

  // A capture meeting the read strobe takes the bus value directly
  assign readValue   = ctlBus.rdStb ? busRdata : holdReg;
  assign captureWord = {{(ADDR_W+1){1'b0}}, readValue};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctlBus.capture) begin
      shiftReg <= captureWord;
    end else if (ctlBus.shift) begin
      shiftReg <= {tdi, shiftReg[SCAN_W-1:1]};
    end
  end

  // Read holding register: filled by the bus read, cleared by any other update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (ctlBus.rdStb) begin
      holdReg <= busRdata;
    end else if (ctlBus.update) begin
      holdReg <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr  <= '0;
      busWdata <= '0;
    end else if (ctlBus.update) begin
      busAddr  <= fieldAddr;
      busWdata <= fieldData;
    end
  end

  assign tdo = ctlBus.active & shiftReg[0];

  // R2: shifting moves every bit one place toward the output
  a_r2_shift_lsb: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlBus.shift) |-> shiftReg[SCAN_W-2:0] == $past(shiftReg[SCAN_W-1:1]));

  // R5: capture without a coincident read loads the held value, upper bits zero
  a_r5_hold_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlBus.capture && !ctlBus.rdStb) |->
      (shiftReg[DATA_W-1:0] == $past(holdReg)) && (shiftReg[SCAN_W-1:DATA_W] == '0));

  // R6: capture coinciding with the read strobe loads that cycle's bus data
  a_r6_forward: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlBus.capture && ctlBus.rdStb) |-> shiftReg[DATA_W-1:0] == $past(busRdata));

  // R7: strobes only ever target an in-range register
  a_r7_range: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBus.wrStb || ctlBus.rdStb) |-> ({1'b0, busAddr} < ADDR_LIMIT));

endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
  import scan_reg_port_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 7,
  parameter int CHAIN_W      = 5,
  parameter int NUM_REGS     = 9,
  parameter int ACTIVE_CHAIN = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chainLoad,
  input  logic [CHAIN_W-1:0] chainIn,
  input  logic               captureEn,
  input  logic               shiftEn,
  input  logic               updateEn,
  input  logic               tdi,
  output logic               tdo,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWdata,
  input  logic [DATA_W-1:0]  busRdata,
  output logic               busWrite,
  output logic               busRead
);

  scanCtlT ctlBus;
  logic    fieldWrite;
  logic    fieldAddrOk;

  scan_reg_port_ctl #(
    .CHAIN_W      (CHAIN_W),
    .ACTIVE_CHAIN (ACTIVE_CHAIN)
  ) ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .chainLoad   (chainLoad),
    .chainIn     (chainIn),
    .captureEn   (captureEn),
    .shiftEn     (shiftEn),
    .updateEn    (updateEn),
    .fieldWrite  (fieldWrite),
    .fieldAddrOk (fieldAddrOk),
    .ctlBus      (ctlBus)
  );

  scan_reg_port_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctlBus      (ctlBus),
    .tdi         (tdi),
    .tdo         (tdo),
    .fieldWrite  (fieldWrite),
    .fieldAddrOk (fieldAddrOk),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata)
  );

  assign busWrite = ctlBus.wrStb;
  assign busRead  = ctlBus.rdStb;

endmodule

// File: tb/scan_reg_port_tb.sv
module scan_reg_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        chainLoad;
  logic [4:0]  chainIn;
  logic        captureEn;
  logic        shiftEn;
  logic        updateEn;
  logic        tdi;
  logic        tdo;
  logic [6:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        busWrite;
  logic        busRead;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          isWr;
    logic [6:0]  addr;
    logic [31:0] data;
  } busEvT;

  busEvT expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  scan_reg_port dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .chainLoad (chainLoad),
    .chainIn   (chainIn),
    .captureEn (captureEn),
    .shiftEn   (shiftEn),
    .updateEn  (updateEn),
    .tdi       (tdi),
    .tdo       (tdo),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .busWrite  (busWrite),
    .busRead   (busRead)
  );

  function automatic logic [31:0] regModel(input logic [6:0] a);
    return 32'h9E37_0000 + 32'(a) * 32'h0101_0011;
  endfunction

  assign busRdata = regModel(busAddr);

  function automatic logic [39:0] mkWord(input bit rw, input logic [6:0] a, input logic [31:0] d);
    return {rw, a, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every strobe must match the next queued expectation
  always @(negedge clk) begin
    if (rstN && (busWrite || busRead)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, busWrite ? "R3 unexpected write strobe" : "R4 unexpected read strobe",
            {57'd0, busAddr}, 64'd0);
      end else begin
        busEvT e;
        e = expQ.pop_front();
        if (e.isWr) begin
          chk(busWrite && !busRead, "R3 write strobe kind", {62'd0, busWrite, busRead}, 64'd2);
          chk(busAddr == e.addr && busWdata == e.data, "R3 write addr/data",
              {25'd0, busAddr, busWdata}, {25'd0, e.addr, e.data});
        end else begin
          chk(busRead && !busWrite, "R4 read strobe kind", {62'd0, busWrite, busRead}, 64'd1);
          chk(busAddr == e.addr, "R4 read addr", {57'd0, busAddr}, {57'd0, e.addr});
        end
      end
    end
  end

  task automatic pushEv(input bit isWr, input logic [6:0] a, input logic [31:0] d);
    busEvT e;
    e.isWr = isWr;
    e.addr = a;
    e.data = d;
    expQ.push_back(e);
  endtask

  // Starts and ends on a falling edge; quick skips the idle cycle before capture
  task automatic doScan(input logic [39:0] w, input bit quick, output logic [39:0] cap);
    if (!quick) @(negedge clk);
    captureEn = 1'b1;
    @(negedge clk);
    captureEn = 1'b0;
    shiftEn   = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi    = w[i];
      cap[i] = tdo;
      @(negedge clk);
    end
    shiftEn  = 1'b0;
    updateEn = 1'b1;
    @(negedge clk);
    updateEn = 1'b0;
  endtask

  task automatic selChain(input logic [4:0] c);
    @(negedge clk);
    chainLoad = 1'b1;
    chainIn   = c;
    @(negedge clk);
    chainLoad = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] cap;
    rstN = 1'b0; chainLoad = 1'b0; chainIn = '0;
    captureEn = 1'b0; shiftEn = 1'b0; updateEn = 1'b0; tdi = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busWrite && !busRead && !tdo, "R1 outputs in reset",
        {61'd0, busWrite, busRead, tdo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busWrite && !busRead && !tdo, "R1 outputs after reset",
        {61'd0, busWrite, busRead, tdo}, 64'd0);

    // R1/R9: reset leaves the port deselected; a write scan must do nothing
    doScan(mkWord(1'b1, 7'd2, 32'h1111_2222), 1'b0, cap);
    repeat (2) @(negedge clk);
    chk(cap == 40'd0, "R9 capture while deselected at reset", {24'd0, cap}, 64'd0);

    selChain(5'd0);

    // R3 write; capture returns zero (nothing read yet)
    pushEv(1'b1, 7'd2, 32'hDEAD_BEEF);
    doScan(mkWord(1'b1, 7'd2, 32'hDEAD_BEEF), 1'b0, cap);
    chk(cap == 40'd0, "R8 capture before any read", {24'd0, cap}, 64'd0);

    // R4 read of 5; capture after a write scan is zero
    pushEv(1'b0, 7'd5, 32'd0);
    doScan(mkWord(1'b0, 7'd5, 32'hFFFF_FFFF), 1'b0, cap);
    chk(cap == 40'd0, "R8 capture after write scan", {24'd0, cap}, 64'd0);

    // R5 pipelined result of read 5, with idle gap
    pushEv(1'b0, 7'd0, 32'd0);
    doScan(mkWord(1'b0, 7'd0, 32'h0), 1'b0, cap);
    chk(cap == {8'd0, regModel(7'd5)}, "R5 pipelined read data addr 5",
        {24'd0, cap}, {32'd0, regModel(7'd5)});

    // R6 back-to-back: capture meets the read strobe of address 0
    pushEv(1'b0, 7'd8, 32'd0);
    doScan(mkWord(1'b0, 7'd8, 32'hA5A5_A5A5), 1'b1, cap);
    chk(cap == {8'd0, regModel(7'd0)}, "R6 forwarded read data addr 0",
        {24'd0, cap}, {32'd0, regModel(7'd0)});

    // R6 again, top in-range address, followed by a write
    pushEv(1'b1, 7'd1, 32'h1234_5678);
    doScan(mkWord(1'b1, 7'd1, 32'h1234_5678), 1'b1, cap);
    chk(cap == {8'd0, regModel(7'd8)}, "R6 forwarded read data addr 8",
        {24'd0, cap}, {32'd0, regModel(7'd8)});

    // R7 read of first out-of-range address: no strobe
    doScan(mkWord(1'b0, 7'd9, 32'h0), 1'b0, cap);
    chk(cap == 40'd0, "R8 capture after write addr 1", {24'd0, cap}, 64'd0);

    // R7 out-of-range write: no strobe; capture of the bad read is zero
    doScan(mkWord(1'b1, 7'd100, 32'hCAFE_F00D), 1'b0, cap);
    chk(cap == 40'd0, "R7 capture after out-of-range read", {24'd0, cap}, 64'd0);

    // R4 read of 3, to be collected after a deselected interval
    pushEv(1'b0, 7'd3, 32'd0);
    doScan(mkWord(1'b0, 7'd3, 32'h0), 1'b0, cap);
    chk(cap == 40'd0, "R7 capture after out-of-range write", {24'd0, cap}, 64'd0);

    // R9: other chain selected; scan ignored, tdo low, no strobe
    selChain(5'd3);
    doScan(mkWord(1'b1, 7'd4, 32'h7777_8888), 1'b0, cap);
    chk(cap == 40'd0, "R9 capture while chain 3 selected", {24'd0, cap}, 64'd0);

    // R9: back on chain 0, held value of read 3 survives the ignored scan
    selChain(5'd0);
    pushEv(1'b0, 7'd0, 32'd0);
    doScan(mkWord(1'b0, 7'd0, 32'h0), 1'b0, cap);
    chk(cap == {8'd0, regModel(7'd3)}, "R9/R5 read data kept across deselect",
        {24'd0, cap}, {32'd0, regModel(7'd3)});

    // R2: capture of a read after the harmless read returns addr 0 data
    doScan(mkWord(1'b1, 7'd120, 32'h0), 1'b0, cap);
    chk(cap[0] == regModel(7'd0)[0] && cap[31:0] == regModel(7'd0) && cap[39:32] == 8'd0,
        "R2 LSB-first field layout", {24'd0, cap}, {32'd0, regModel(7'd0)});

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R4 every expected strobe seen once",
        64'(expQ.size()), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule